// File: doc/BRIEF.md
# Field-Masked Calendar Alarm Comparator

This block watches a running BCD calendar and raises an alarm interrupt when the time matches a programmed alarm. Once per second, the calendar advances its time and then pulses a strobe. On that strobe the block compares six BCD fields against stored alarm values: second, minute, hour, day of month, month and a three-digit year. Each comparison counts only if that field's own enable bit is set. The alarm fires when any enabled field matches, not when all of them match. A separate global enable bit gates the whole check.

Software programs the alarm through a simple write port made of a register select, a data word and a write strobe. Alarm values are trimmed to the width of their field when they are written. A match sets a sticky pending flag, and the interrupt line follows that flag. Software clears the flag by writing a one to bit 1 of the pending register. The calendar counter itself lives outside this block.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the pending flag and the interrupt are low. Every alarm value, every field enable and the global enable are zero, so a strobe with an all-zero time does not fire.
- R2: Writing select 0 loads the control register. Bits 0..5 enable the second, minute, hour, day, month and year fields, and bit 6 is the global enable. Selects 1..6 load the second, minute, hour, day, month and year alarm values. Select 7 is the pending register.
- R3: A comparison happens only in a cycle where `sec_tick` is high and the global enable is set. A resulting match shows on `alarm_pending` after the next rising clock edge.
- R4: The alarm fires when at least one enabled field equals its alarm value. Fields whose enable bit is clear never cause a fire.
- R5: Alarm values are masked when written: second and minute to 7 bits, hour and day to 6 bits, month to 5 bits, and year to 12 bits. The upper data bits are discarded.
- R6: The year compares as 12 bits, holding two BCD digits in bits 7:0 and the hundreds digit in bits 11:8. A difference in the hundreds digit alone prevents a year match.
- R7: `alarm_irq` is high exactly while the pending flag is set. Once set, the flag stays set through later strobes, matching or not, until software clears it.
- R8: A write to select 7 with data bit 1 set clears the pending flag. The same write with bit 1 clear leaves the flag unchanged.
- R9: If a qualifying match and a clear write arrive in the same cycle, the flag ends up set.
- R10: With the global enable clear, strobes never set the flag, even if enabled fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe after the calendar advances a second |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R2) |
| wr_data | input | 16 | Write data |
| alarm_pending | output | 1 | Sticky alarm pending flag (pending register bit 1) |
| alarm_irq | output | 1 | Alarm interrupt line |

## Verification
On every cycle, the assertions check four things. A qualifying strobe with any enabled match sets the flag on the next edge. The flag only rises after a strobe taken with the global enable set. The flag holds unless a clear is written. A clear with no simultaneous match drops the flag. A control write is also checked to land in the control register. Only the bench scenarios can show the remaining behaviour: the field-by-field bit positions, the width trimming of each alarm value, the hundreds-digit year compare, and the OR-not-AND combining of fields. These depend on chosen values and on the absence of a fire.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
    localparam int NUM_FIELDS = 6;
    localparam int CMP_W      = 12;
    localparam int SEL_W      = 3;
    localparam int DATA_W     = 16;
    localparam int CTRL_W     = NUM_FIELDS + 1;
    localparam int GLB_BIT    = NUM_FIELDS;
    localparam int PEND_BIT   = 1;

    localparam int W_SEC  = 7;
    localparam int W_MIN  = 7;
    localparam int W_HOUR = 6;
    localparam int W_DAY  = 6;
    localparam int W_MON  = 5;
    localparam int W_YEAR = 12;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_SEC  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MIN  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_HOUR = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DAY  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_MON  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_YEAR = 3'd6;
    localparam logic [SEL_W-1:0] SEL_PEND = 3'd7;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [W_SEC-1:0]  sec;
        logic [W_MIN-1:0]  min;
        logic [W_HOUR-1:0] hour;
        logic [W_DAY-1:0]  day;
        logic [W_MON-1:0]  mon;
        logic [W_YEAR-1:0] year;
    } alm_regs_t;

    typedef struct packed {
        logic pend;
    } pend_state_t;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output alm_regs_t         regs_q
);
    alm_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: regs_d.ctrl = wr_data[CTRL_W-1:0];
                SEL_SEC:  regs_d.sec  = wr_data[W_SEC-1:0];
                SEL_MIN:  regs_d.min  = wr_data[W_MIN-1:0];
                SEL_HOUR: regs_d.hour = wr_data[W_HOUR-1:0];
                SEL_DAY:  regs_d.day  = wr_data[W_DAY-1:0];
                SEL_MON:  regs_d.mon  = wr_data[W_MON-1:0];
                SEL_YEAR: regs_d.year = wr_data[W_YEAR-1:0];
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R2: a control write lands in the control register
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> (regs_q.ctrl == $past(wr_data[CTRL_W-1:0])));
endmodule

// File: rtl/cal_alarm_fields.sv
module cal_alarm_fields
    import cal_alarm_pkg::*;
#(
    parameter int N = NUM_FIELDS,
    parameter int W = CMP_W
) (
    input  logic [N*W-1:0] cur_flat,
    input  logic [N*W-1:0] alm_flat,
    input  logic [N-1:0]   field_en,
    output logic [N-1:0]   hit
);
    for (genvar i = 0; i < N; i++) begin : g_field
        assign hit[i] = field_en[i] && (cur_flat[i*W +: W] == alm_flat[i*W +: W]);
    end
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_day,
    input  logic [7:0]        cur_mon,
    input  logic [11:0]       cur_year,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              alarm_pending,
    output logic              alarm_irq
);
    alm_regs_t               regs;
    logic [NUM_FIELDS*CMP_W-1:0] cur_flat;
    logic [NUM_FIELDS*CMP_W-1:0] alm_flat;
    logic [NUM_FIELDS-1:0]   hit;
    logic                    glb_en;
    logic                    fire;
    logic                    clr_req;
    pend_state_t             st_d, st_q;

    cal_alarm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs)
    );

    // field order in the flat vectors follows the enable bit order
    assign cur_flat = {cur_year,
                       4'd0, cur_mon,
                       4'd0, cur_day,
                       4'd0, cur_hour,
                       4'd0, cur_min,
                       4'd0, cur_sec};
    assign alm_flat = {regs.year,
                       {(CMP_W-W_MON){1'b0}},  regs.mon,
                       {(CMP_W-W_DAY){1'b0}},  regs.day,
                       {(CMP_W-W_HOUR){1'b0}}, regs.hour,
                       {(CMP_W-W_MIN){1'b0}},  regs.min,
                       {(CMP_W-W_SEC){1'b0}},  regs.sec};

    cal_alarm_fields #(.N(NUM_FIELDS), .W(CMP_W)) u_fields (
        .cur_flat (cur_flat),
        .alm_flat (alm_flat),
        .field_en (regs.ctrl[NUM_FIELDS-1:0]),
        .hit      (hit)
    );

    assign glb_en  = regs.ctrl[GLB_BIT];
    assign fire    = sec_tick && glb_en && (|hit);
    assign clr_req = wr_en && (wr_sel == SEL_PEND) && wr_data[PEND_BIT];

    always_comb begin
        st_d = st_q;
        if (clr_req) st_d.pend = 1'b0;
        if (fire)    st_d.pend = 1'b1;   // a new match outranks a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_pending = st_q.pend;
    assign alarm_irq     = st_q.pend;

    // R4, R9: any qualifying match sets the flag on the next edge
    p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && regs.ctrl[GLB_BIT] && (|hit)) |=> alarm_pending);
    // R3, R10: the flag only rises after a strobe taken with global enable
    p_rise_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_pending) |-> $past(sec_tick && regs.ctrl[GLB_BIT]));
    // R7: the flag holds until a clear is written
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_pending && !(wr_en && wr_sel == SEL_PEND && wr_data[PEND_BIT])) |=> alarm_pending);
    // R8: a clear with no simultaneous match drops the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PEND && wr_data[PEND_BIT] && !(sec_tick && regs.ctrl[GLB_BIT] && (|hit)))
        |=> !alarm_pending);
endmodule

// File: tb/sim_cal_alarm_match.sv
module sim_cal_alarm_match;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [7:0]  cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0, cur_mon = '0;
    logic [11:0] cur_year = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        alarm_pending, alarm_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_alarm_match u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_mon(cur_mon), .cur_year(cur_year),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .alarm_pending(alarm_pending), .alarm_irq(alarm_irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_flag(input string tag, input logic exp);
        check({tag, " pending"}, alarm_pending, exp);
        check({tag, " irq"}, alarm_irq, exp);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] d, input logic [7:0] mo, input logic [11:0] y);
        cur_sec = s; cur_min = mi; cur_hour = h; cur_day = d; cur_mon = mo; cur_year = y;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic clear_pend();
        wr(3'd7, 16'h0002);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check_flag("R1 after reset", 1'b0);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        tick();
        check_flag("R1 zero time, disabled", 1'b0);
        wr(3'd0, 16'h0040);
        tick();
        check_flag("R1 global only, no fields", 1'b0);
    endtask

    task automatic t_each_field();
        logic [7:0]  vals [6];
        vals = '{8'h42, 8'h17, 8'h23, 8'h28, 8'h11, 8'h00};
        for (int f = 0; f < 6; f++) begin
            do_reset();
            wr(3'd1, 16'h0042); wr(3'd2, 16'h0017); wr(3'd3, 16'h0023);
            wr(3'd4, 16'h0028); wr(3'd5, 16'h0011); wr(3'd6, 16'h0987);
            wr(3'd0, 16'h0040 | (16'h1 << f));
            // only field f matches
            set_time(8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 12'h001);
            case (f)
                0: cur_sec  = vals[0];
                1: cur_min  = vals[1];
                2: cur_hour = vals[2];
                3: cur_day  = vals[3];
                4: cur_mon  = vals[4];
                default: cur_year = 12'h987;
            endcase
            tick();
            check_flag($sformatf("R2 R4 field %0d alone", f), 1'b1);
            // enable a different field only: the same time must not fire
            clear_pend();
            wr(3'd0, 16'h0040 | (16'h1 << ((f + 1) % 6)));
            tick();
            check_flag($sformatf("R4 field %0d match but disabled", f), 1'b0);
        end
    endtask

    task automatic t_or();
        do_reset();
        wr(3'd1, 16'h0030); wr(3'd2, 16'h0045);
        wr(3'd0, 16'h0043);
        set_time(8'h30, 8'h10, 8'h00, 8'h01, 8'h01, 12'h000);
        tick();
        check_flag("R4 one of two enabled matches", 1'b1);
        clear_pend();
        set_time(8'h31, 8'h10, 8'h00, 8'h01, 8'h01, 12'h000);
        tick();
        check_flag("R4 neither enabled matches", 1'b0);
    endtask

    task automatic t_global_and_tick();
        do_reset();
        wr(3'd1, 16'h0005);
        wr(3'd0, 16'h003F);
        set_time(8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        tick();
        check_flag("R10 global off, field matches", 1'b0);
        wr(3'd0, 16'h0041);
        repeat (3) @(negedge clk);
        check_flag("R3 no strobe, no compare", 1'b0);
        @(negedge clk);
        sec_tick = 1'b1;
        #1;
        check("R3 not before edge", alarm_pending, 1'b0);
        @(negedge clk);
        sec_tick = 1'b0;
        check_flag("R3 one edge after strobe", 1'b1);
    endtask

    task automatic t_mask();
        do_reset();
        wr(3'd1, 16'hFFFF);
        wr(3'd0, 16'h0041);
        set_time(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        tick();
        check_flag("R5 sec stored as 7 bits, 0xFF no match", 1'b0);
        cur_sec = 8'h7F;
        tick();
        check_flag("R5 sec stored as 0x7F", 1'b1);
        do_reset();
        wr(3'd3, 16'hFFFF); wr(3'd0, 16'h0044);
        cur_hour = 8'h3F;
        tick();
        check_flag("R5 hour stored as 0x3F", 1'b1);
        do_reset();
        wr(3'd5, 16'hFFFF); wr(3'd0, 16'h0050);
        cur_mon = 8'h1F;
        tick();
        check_flag("R5 month stored as 0x1F", 1'b1);
        do_reset();
        wr(3'd6, 16'hFFFF); wr(3'd0, 16'h0060);
        cur_year = 12'hFFF;
        tick();
        check_flag("R5 year stored as 0xFFF", 1'b1);
    endtask

    task automatic t_year();
        do_reset();
        wr(3'd6, 16'h0123);
        wr(3'd0, 16'h0060);
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 12'h223);
        tick();
        check_flag("R6 hundreds digit differs", 1'b0);
        cur_year = 12'h124;
        tick();
        check_flag("R6 low digits differ", 1'b0);
        cur_year = 12'h123;
        tick();
        check_flag("R6 full year match", 1'b1);
    endtask

    task automatic t_sticky_clear();
        do_reset();
        wr(3'd1, 16'h0009);
        wr(3'd0, 16'h0041);
        set_time(8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 12'h000);
        tick();
        check_flag("R7 set", 1'b1);
        cur_sec = 8'h10;
        tick(); tick();
        check_flag("R7 stays set on non-matching strobes", 1'b1);
        wr(3'd7, 16'h0001);
        check_flag("R8 bit1 clear leaves flag", 1'b1);
        wr(3'd6, 16'h0002);
        check_flag("R8 other select leaves flag", 1'b1);
        clear_pend();
        check_flag("R8 W1C clears", 1'b0);
        cur_sec = 8'h09;
        @(negedge clk);
        sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd7; wr_data = 16'h0002;
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        check_flag("R9 match and clear together", 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_each_field();
                t_or();
                t_global_and_tick();
                t_mask();
                t_year();
                t_sticky_clear();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: actual hung expected finished");
                end
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule